// File: doc/BRIEF.md
# Prefetch Request Tracker

This block sits between a processor and its local cache and tracks prefetch requests that are still waiting for the interconnect. Each prefetch names one subpage address and the state the processor wants for it: shared or exclusive. The processor does not wait for a prefetch to complete. The block compares the request against the state the local cache already holds for that address. It then either discards the request, merges it into a request that is already outstanding, or records it in a small table and raises a request toward the ring.

A response strobe carries the address of a subpage that has arrived, and it frees the matching table entry. Responses may come back in any order.

When the table is full, the request's blocking flag decides what happens:
- A non-blocking request is dropped, and a wrapping drop counter is incremented.
- A blocking request is parked in a one-deep hold slot. The processor is then stalled at its next local-cache access until an entry frees and the parked request is issued.

Top module: `pfq_top`

## Requirements
- R1: After reset no ring request is raised, `stall` is low, `drop_count` is 0 and every table entry is free.
- R2: A prefetch whose address is neither held nor outstanding, issued while the table has a free entry, raises exactly one `ring_req_valid` pulse in the cycle after it is presented, carrying its address and required state (`ring_req_excl`: 1 = exclusive, 0 = shared).
- R3: `held_state` encodes the local copy of `pf_addr`: 2'b00 none, 2'b01 shared, 2'b1x exclusive. A prefetch for an address already held in a state that covers the request is discarded: no ring request and no table entry. Exclusive covers shared; shared does not cover exclusive.
- R4: A prefetch to an address already outstanding, whose required state is already covered by the outstanding entry, is merged: no ring request and no new entry.
- R5: An exclusive prefetch to an address outstanding only as shared upgrades that entry in place. It raises one ring request with `ring_req_excl`=1 and takes no new entry.
- R6: The table holds DEPTH (default 4) outstanding entries. A non-blocking prefetch that needs an entry while all are taken raises no ring request, and `drop_count` is one higher in the next cycle.
- R7: A blocking prefetch that needs an entry while the table is full is held. While it is held, `stall` is high in any cycle with `lc_access` or `pf_valid` high, and new prefetches are not taken. In the cycle after a response frees an entry, the held request takes that entry. In the cycle after that, its ring request appears and `stall` goes low.
- R8: A response whose address matches an outstanding entry frees that entry, whatever order the entries were allocated in. A later prefetch to that address is treated as new.
- R9: A response that matches no outstanding entry changes nothing.
- R10: While no blocking request is held, `stall` stays low, whatever `lc_access` and `pf_valid` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch presented this cycle |
| pf_addr | input | AW | Subpage address of the prefetch |
| pf_excl | input | 1 | Required state: 1 exclusive, 0 shared |
| pf_block | input | 1 | Blocking prefetch |
| held_state | input | 2 | Local cache state of `pf_addr` |
| lc_access | input | 1 | Processor local-cache access this cycle |
| rsp_valid | input | 1 | Ring response arrived |
| rsp_addr | input | AW | Subpage address of the response |
| ring_req_valid | output | 1 | Ring request pulse |
| ring_req_addr | output | AW | Address of the ring request |
| ring_req_excl | output | 1 | State asked for by the ring request |
| stall | output | 1 | Processor stall |
| drop_count | output | DW | Count of dropped non-blocking prefetches |

## Verification
The hardest state to reach is a blocking request parked while all four entries are taken, and then released by a response that arrives while the processor keeps trying to access the cache. Reaching it takes a precise sequence of fills and frees.

The stimulus first fills the table with a mix of fresh, merged and upgraded requests. It confirms the table is full by watching a non-blocking prefetch get dropped, and that an unmatched response leaves it full. It then frees one entry out of allocation order, refills the table, and parks a blocking request. Finally it holds `lc_access` high across the releasing response, so that `stall` and the reissued ring request can be checked cycle by cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // What the tracker does with a presented prefetch.
  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_DISCARD = 3'd1,
    ACT_MERGE   = 3'd2,
    ACT_UPGRADE = 3'd3,
    ACT_ALLOC   = 3'd4,
    ACT_HOLD    = 3'd5,
    ACT_DROP    = 3'd6
  } pf_act_e;

  // A held copy satisfies the request when it is at least as strong.
  function automatic logic state_covers(input logic [1:0] held, input logic want_excl);
    return want_excl ? held[1] : (held != 2'b00);
  endfunction

  // Decide the fate of one prefetch from the lookups.
  function automatic pf_act_e classify(
    input logic taken,
    input logic covered,
    input logic hit,
    input logic hit_excl,
    input logic want_excl,
    input logic full,
    input logic block
  );
    if (!taken)                 return ACT_NONE;
    if (covered)                return ACT_DISCARD;
    if (hit && (hit_excl || !want_excl)) return ACT_MERGE;
    if (hit)                    return ACT_UPGRADE;
    if (!full)                  return ACT_ALLOC;
    if (block)                  return ACT_HOLD;
    return ACT_DROP;
  endfunction

endpackage

// File: rtl/pfq_entry_table.sv
module pfq_entry_table #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          alloc_en,
  input  logic [AW-1:0] alloc_addr,
  input  logic          alloc_excl,
  input  logic          upg_en,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_addr,
  output logic          full,
  output logic          hit,
  output logic          hit_excl
);

  logic [DEPTH-1:0]         ent_valid;
  logic [DEPTH-1:0]         ent_excl;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0]         rsp_match;
  logic [DEPTH-1:0]         lk_match;
  logic [IW-1:0]            free_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rsp_match[i] = ent_valid[i] && rsp_valid && (ent_addr[i] == rsp_addr);
      lk_match[i]  = ent_valid[i] && !rsp_match[i] && (ent_addr[i] == lk_addr);
    end
  end

  assign full     = &ent_valid;
  assign hit      = |lk_match;
  assign hit_excl = |(lk_match & ent_excl);

  // Lowest free slot wins.
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IW'(i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_excl[g]  <= 1'b0;
        ent_addr[g]  <= '0;
      end else if (rsp_match[g]) begin
        ent_valid[g] <= 1'b0;
      end else if (alloc_en && !ent_valid[g] && (free_idx == IW'(g))) begin
        ent_valid[g] <= 1'b1;
        ent_excl[g]  <= alloc_excl;
        ent_addr[g]  <= alloc_addr;
      end else if (upg_en && lk_match[g]) begin
        ent_excl[g]  <= 1'b1;
      end
    end
  end

  // R4: merging keeps addresses unique, so a response hits one entry at most
  p_unique_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_match));

  // R6: the top never asks for an entry while all are taken
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);

  // R5: an upgrade always lands on a live entry
  p_upgrade_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upg_en |-> hit);

endmodule

// File: rtl/pfq_hold_slot.sv
module pfq_hold_slot #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          load_excl,
  input  logic          full_in,
  output logic          pend_valid,
  output logic [AW-1:0] pend_addr,
  output logic          pend_excl,
  output logic          drain
);

  assign drain = pend_valid && !full_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_excl  <= 1'b0;
    end else if (drain) begin
      pend_valid <= 1'b0;
    end else if (load) begin
      pend_valid <= 1'b1;
      pend_addr  <= load_addr;
      pend_excl  <= load_excl;
    end
  end

  // R7: a held request keeps its address until it is issued
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && $past(pend_valid)) |-> $stable(pend_addr));

  // R7: once an entry is free the held request leaves the slot
  p_hold_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !full_in) |=> !pend_valid);

endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_valid,
  input  logic [AW-1:0] pf_addr,
  input  logic          pf_excl,
  input  logic          pf_block,
  input  logic [1:0]    held_state,
  input  logic          lc_access,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_addr,
  output logic          ring_req_valid,
  output logic [AW-1:0] ring_req_addr,
  output logic          ring_req_excl,
  output logic          stall,
  output logic [DW-1:0] drop_count
);

  logic          tbl_full, tbl_hit, tbl_hit_excl;
  logic          pend_valid, pend_excl, drain;
  logic [AW-1:0] pend_addr;
  logic          taken;
  pf_act_e       act;
  logic          alloc_en, upg_en, hold_load, drop_ev;
  logic [AW-1:0] alloc_addr;
  logic          alloc_excl;

  // A held request occupies the processor's access slot.
  assign taken = pf_valid && !pend_valid;
  assign stall = pend_valid && (pf_valid || lc_access);

  assign act = classify(taken, state_covers(held_state, pf_excl), tbl_hit,
                        tbl_hit_excl, pf_excl, tbl_full, pf_block);

  assign hold_load  = (act == ACT_HOLD);
  assign drop_ev    = (act == ACT_DROP);
  assign upg_en     = (act == ACT_UPGRADE);
  assign alloc_en   = (act == ACT_ALLOC) || drain;
  assign alloc_addr = drain ? pend_addr : pf_addr;
  assign alloc_excl = drain ? pend_excl : pf_excl;

  pfq_entry_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_addr    (pf_addr),
    .alloc_en   (alloc_en),
    .alloc_addr (alloc_addr),
    .alloc_excl (alloc_excl),
    .upg_en     (upg_en),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .full       (tbl_full),
    .hit        (tbl_hit),
    .hit_excl   (tbl_hit_excl)
  );

  pfq_hold_slot #(.AW(AW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (hold_load),
    .load_addr  (pf_addr),
    .load_excl  (pf_excl),
    .full_in    (tbl_full),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_excl  (pend_excl),
    .drain      (drain)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_req_valid <= 1'b0;
      ring_req_addr  <= '0;
      ring_req_excl  <= 1'b0;
      drop_count     <= '0;
    end else begin
      ring_req_valid <= alloc_en || upg_en;
      if (alloc_en || upg_en) begin
        ring_req_addr <= alloc_addr;
        ring_req_excl <= upg_en ? 1'b1 : alloc_excl;
      end
      if (drop_ev) drop_count <= drop_count + DW'(1);
    end
  end

  // R6: the drop counter only ever steps by one
  p_drop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DW'(1)));

  // R10: no stall without a held request
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> !stall);

endmodule

// File: tb/pfq_top_bench.sv
`timescale 1ns/1ps
module pfq_top_bench;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pf_valid = 1'b0;
  logic [AW-1:0] pf_addr = '0;
  logic          pf_excl = 1'b0;
  logic          pf_block = 1'b0;
  logic [1:0]    held_state = 2'b00;
  logic          lc_access = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [AW-1:0] rsp_addr = '0;
  logic          ring_req_valid;
  logic [AW-1:0] ring_req_addr;
  logic          ring_req_excl;
  logic          stall;
  logic [DW-1:0] drop_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfq_top #(.DEPTH(4), .AW(AW), .DW(DW)) u_pfq_top (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_excl(pf_excl), .pf_block(pf_block), .held_state(held_state),
    .lc_access(lc_access), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .ring_req_valid(ring_req_valid), .ring_req_addr(ring_req_addr),
    .ring_req_excl(ring_req_excl), .stall(stall), .drop_count(drop_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one prefetch for one cycle; outputs are sampled after that edge.
  task automatic prefetch(input logic [AW-1:0] a, input logic ex, input logic blk,
                          input logic [1:0] held);
    @(negedge clk);
    pf_valid = 1'b1; pf_addr = a; pf_excl = ex; pf_block = blk; held_state = held;
    @(posedge clk); #1;
    pf_valid = 1'b0; held_state = 2'b00;
  endtask

  task automatic respond(input logic [AW-1:0] a);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_addr = a;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic expect_req(input string req, input logic [AW-1:0] a, input logic ex);
    chk(req, {31'd0, ring_req_valid}, 32'd1);
    chk(req, {16'd0, ring_req_addr}, {16'd0, a});
    chk(req, {31'd0, ring_req_excl}, {31'd0, ex});
  endtask

  task automatic expect_none(input string req);
    chk(req, {31'd0, ring_req_valid}, 32'd0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 ring_req", {31'd0, ring_req_valid}, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 drop_count", {24'd0, drop_count}, 32'd0);
  endtask

  task automatic t_fresh;
    prefetch(16'h0010, 1'b0, 1'b0, 2'b00); expect_req("R2 shared", 16'h0010, 1'b0);
    @(posedge clk); #1; expect_none("R2 single pulse");
    prefetch(16'h0011, 1'b1, 1'b0, 2'b01); expect_req("R2 excl over shared", 16'h0011, 1'b1);
  endtask

  task automatic t_covered;
    prefetch(16'h0012, 1'b0, 1'b0, 2'b01); expect_none("R3 shared held");
    prefetch(16'h0012, 1'b1, 1'b0, 2'b10); expect_none("R3 excl held");
    prefetch(16'h0012, 1'b0, 1'b0, 2'b11); expect_none("R3 excl covers shared");
  endtask

  task automatic t_merge;
    prefetch(16'h0010, 1'b0, 1'b0, 2'b00); expect_none("R4 dup shared");
    prefetch(16'h0011, 1'b0, 1'b0, 2'b00); expect_none("R4 shared onto excl");
    prefetch(16'h0010, 1'b1, 1'b0, 2'b00); expect_req("R5 upgrade", 16'h0010, 1'b1);
    prefetch(16'h0010, 1'b1, 1'b0, 2'b00); expect_none("R5 after upgrade");
  endtask

  task automatic t_full_drop;
    prefetch(16'h0013, 1'b0, 1'b0, 2'b00); expect_req("R3 entry 3 free", 16'h0013, 1'b0);
    prefetch(16'h0014, 1'b0, 1'b0, 2'b00); expect_req("R4 entry 4 free", 16'h0014, 1'b0);
    prefetch(16'h0015, 1'b0, 1'b0, 2'b00); expect_none("R6 drop no req");
    chk("R6 drop_count", {24'd0, drop_count}, 32'd1);
    prefetch(16'h0016, 1'b1, 1'b0, 2'b00);
    chk("R6 drop_count 2", {24'd0, drop_count}, 32'd2);
  endtask

  task automatic t_stray;
    respond(16'h0077); expect_none("R9 no req");
    prefetch(16'h0015, 1'b0, 1'b0, 2'b00); expect_none("R9 still full");
    chk("R9 drop_count", {24'd0, drop_count}, 32'd3);
  endtask

  task automatic t_out_of_order;
    respond(16'h0013);
    prefetch(16'h0015, 1'b0, 1'b0, 2'b00); expect_req("R8 freed slot", 16'h0015, 1'b0);
    chk("R8 no drop", {24'd0, drop_count}, 32'd3);
  endtask

  task automatic t_block;
    prefetch(16'h0020, 1'b1, 1'b1, 2'b00); expect_none("R7 held no req");
    chk("R7 no drop", {24'd0, drop_count}, 32'd3);
    @(negedge clk); lc_access = 1'b1; #1;
    chk("R7 stall on access", {31'd0, stall}, 32'd1);
    @(negedge clk); lc_access = 1'b0; pf_valid = 1'b1; pf_addr = 16'h0030; #1;
    chk("R7 stall on prefetch", {31'd0, stall}, 32'd1);
    @(posedge clk); #1; pf_valid = 1'b0;
    expect_none("R7 prefetch not taken");
    @(negedge clk); lc_access = 1'b0; #1;
    chk("R7 no stall idle", {31'd0, stall}, 32'd0);
    lc_access = 1'b1;
    respond(16'h0010);
    chk("R7 stall until issued", {31'd0, stall}, 32'd1);
    expect_none("R7 not yet issued");
    @(posedge clk); #1;
    expect_req("R7 held issued", 16'h0020, 1'b1);
    chk("R7 stall released", {31'd0, stall}, 32'd0);
    @(negedge clk); lc_access = 1'b0;
  endtask

  task automatic t_drain_refill;
    respond(16'h0020); respond(16'h0014); respond(16'h0011); respond(16'h0015);
    prefetch(16'h0014, 1'b0, 1'b0, 2'b00); expect_req("R8 freed addr new", 16'h0014, 1'b0);
    @(negedge clk); lc_access = 1'b1; #1;
    chk("R10 access no stall", {31'd0, stall}, 32'd0);
    @(negedge clk); lc_access = 1'b0;
    prefetch(16'h0040, 1'b0, 1'b1, 2'b00); expect_req("R10 blocking not full", 16'h0040, 1'b0);
    prefetch(16'h0041, 1'b1, 1'b0, 2'b00); expect_req("R2 third", 16'h0041, 1'b1);
    prefetch(16'h0042, 1'b0, 1'b0, 2'b00); expect_req("R2 fourth", 16'h0042, 1'b0);
    chk("R10 stall low", {31'd0, stall}, 32'd0);
    chk("R6 drops unchanged", {24'd0, drop_count}, 32'd3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_fresh();
    t_covered();
    t_merge();
    t_full_drop();
    t_stray();
    t_out_of_order();
    t_block();
    t_drain_refill();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule